// File: doc/BRIEF.md
# SPI Flash Page-Write Sequencer

This block is a host-side SPI master that stores a run of bytes into one page of a serial NOR flash. A client gives a start pulse together with a 24-bit target address and a byte count. It then supplies the payload on a byte stream with a valid/ready handshake. The sequencer runs three kinds of SPI transaction in order. The first is a one-byte write-enable. The second is a page-program transaction carrying the opcode, the address and the payload. The last is a read-status transaction, repeated until the flash reports that its internal write has finished. The block then pulses `done_o`. If the flash stays busy for too long it pulses `error_o` instead.

The bus runs in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising edge. The half-period of SCLK, the minimum chip-select high time and the busy-poll limit are parameters. The byte count is cut to the space left in the addressed page, so the flash never wraps back to the start of the page. A request whose count is zero finishes at once and causes no bus activity.

Top module: `spi_page_writer`

## Requirements
- R1: A start with a length of zero pulses `done_o` in the cycle after the start. It raises no `busy_o`, drives `cs_n_o` low for no transaction and accepts no stream byte.
- R2: For a nonzero length, the first transaction holds `cs_n_o` low for exactly one byte, 0x06.
- R3: The second transaction sends 0x02, then the address bytes from bits 23:16 down to bits 7:0, then the payload bytes in stream order, all in one `cs_n_o`-low window.
- R4: The number of payload bytes sent and taken from the stream equals min(length, 256 − address[7:0]). `len_i` is 9 bits wide, so 256 and larger counts are legal and are clipped the same way.
- R5: SPI mode 0 holds on the bus. SCLK is low whenever `cs_n_o` is high, MOSI never changes while SCLK is high, and every `cs_n_o`-low window holds a whole number of bytes, so `cs_n_o` rises only after the eighth bit of the last byte.
- R6: After the program transaction, the block repeats a two-byte status transaction: 0x05 followed by one byte read from MISO. BUSY is bit 0 of the status byte. `done_o` pulses right after the first status read that shows BUSY = 0, and not earlier.
- R7: Between two transactions, `cs_n_o` stays high for at least `CS_GAP` clock cycles.
- R8: A cycle counter starts when the program transaction ends. A status read that still shows BUSY after `POLL_LIMIT` cycles have passed ends the request with a one-cycle `error_o` and no `done_o`. A read that shows BUSY clear gives `done_o` even when the limit has already passed.
- R9: A payload byte moves only in a cycle where both `data_valid_i` and `data_ready_o` are high. While the stream stalls, `cs_n_o` stays low and no extra byte is sent.
- R10: A start pulse while `busy_o` is high is ignored.
- R11: `busy_o` rises in the cycle after an accepted nonzero start and falls with the `done_o` or `error_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request pulse, taken when idle |
| addr_i | input | 24 | Flash byte address of the first payload byte |
| len_i | input | 9 | Requested payload byte count (0 to 511) |
| data_i | input | 8 | Payload stream byte |
| data_valid_i | input | 1 | Payload stream valid |
| data_ready_o | output | 1 | Payload stream ready |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle pulse: page written |
| error_o | output | 1 | One-cycle pulse: busy-poll limit exceeded |
| sclk_o | output | 1 | SPI clock, mode 0 |
| cs_n_o | output | 1 | SPI chip select, active low |
| mosi_o | output | 1 | SPI data to the flash |
| miso_i | input | 1 | SPI data from the flash |

## Verification
The end of a status read can coincide with the expiry of the poll limit, and the block must then choose between `done_o` and `error_o` in that one cycle. With the bench parameters, one status poll takes 71 cycles and the limit is 400 cycles. The flash model is told how many reads should still report BUSY. With five busy reads, the sixth read shows BUSY clear after the limit has passed, and the bench expects `done_o` after exactly six status transactions. With six busy reads, the sixth read still shows BUSY past the limit, and the bench expects `error_o`, no `done_o`, and again six status transactions.

// File: rtl/spi_pw_pkg.sv
package spi_pw_pkg;
  localparam logic [7:0] OP_WR_ENABLE = 8'h06;
  localparam logic [7:0] OP_PROGRAM   = 8'h02;
  localparam logic [7:0] OP_READ_STAT = 8'h05;
  localparam logic [7:0] ST_BUSY_MASK = 8'h01;

  typedef enum logic [1:0] {
    S_IDLE,
    S_GAP,
    S_CMD
  } seq_state_e;

  typedef enum logic [1:0] {
    T_WREN,
    T_PROG,
    T_RDSR
  } txn_kind_e;
endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic [7:0] rx_o,
  output logic       done_o,
  output logic       active_o
);
  localparam int CNT_W = (HALF_CLKS > 1) ? $clog2(HALF_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CLKS - 1);

  logic             active_q;
  logic [CNT_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       sh_q;
  logic [7:0]       rx_q;
  logic             sclk_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active_q) begin
        if (go_i) begin
          active_q <= 1'b1;
          sh_q     <= tx_i;
          cnt_q    <= '0;
          bit_q    <= '0;
        end
      end else if (cnt_q == CNT_LAST) begin
        cnt_q <= '0;
        if (!sclk_q) begin
          // rising edge: the flash samples MOSI, the host samples MISO
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[6:0], miso_i};
        end else begin
          // falling edge: next bit goes out, or the byte is complete
          sclk_q <= 1'b0;
          if (bit_q == 3'd7) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end else begin
            bit_q <= bit_q + 3'd1;
            sh_q  <= {sh_q[6:0], 1'b0};
          end
        end
      end else begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign sclk_o   = sclk_q;
  assign mosi_o   = sh_q[7];
  assign rx_o     = rx_q;
  assign done_o   = done_q;
  assign active_o = active_q;

  // R5: a new byte is only launched once the previous one has finished
  p_go_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !active_q);
endmodule

// File: rtl/spi_page_clip.sv
module spi_page_clip #(
  parameter int PAGE_BYTES = 256,
  parameter int LEN_W      = $clog2(PAGE_BYTES) + 1,
  parameter int OFF_W      = $clog2(PAGE_BYTES)
) (
  input  logic [OFF_W-1:0] offset_i,
  input  logic [LEN_W-1:0] len_i,
  output logic [LEN_W-1:0] len_o
);
  logic [LEN_W-1:0] room;

  always_comb begin
    room  = LEN_W'(PAGE_BYTES) - LEN_W'(offset_i);
    len_o = (len_i > room) ? room : len_i;
  end
endmodule

// File: rtl/spi_page_writer.sv
module spi_page_writer
  import spi_pw_pkg::*;
#(
  parameter int SCLK_HALF  = 2,
  parameter int CS_GAP     = 4,
  parameter int POLL_LIMIT = 100000,
  parameter int PAGE_BYTES = 256,
  parameter int ADDR_W     = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [8:0]        len_i,
  input  logic [7:0]        data_i,
  input  logic              data_valid_i,
  output logic              data_ready_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              error_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o,
  input  logic              miso_i
);
  localparam int OFF_W = $clog2(PAGE_BYTES);
  localparam int LEN_W = OFF_W + 1;
  localparam int IDX_W = LEN_W + 1;
  localparam int GAP_W = $clog2(CS_GAP + 1);
  localparam int TMO_W = $clog2(POLL_LIMIT + 1);
  localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
  localparam logic [TMO_W-1:0] TMO_MAX  = TMO_W'(POLL_LIMIT);

  seq_state_e        state_q;
  txn_kind_e         txn_q, nxt_q;
  logic [IDX_W-1:0]  idx_q;
  logic              inflight_q;
  logic              cs_n_q;
  logic [GAP_W-1:0]  gcnt_q;
  logic [TMO_W-1:0]  tmo_q;
  logic              polling_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              done_q, err_q, busy_q;

  logic [LEN_W-1:0]  clip_len;
  logic [7:0]        tx_byte;
  logic              need_data, issue, last_byte, tmo_hit;
  logic              eng_done, eng_active;
  logic [7:0]        eng_rx;

  spi_page_clip #(
    .PAGE_BYTES(PAGE_BYTES),
    .LEN_W     (LEN_W),
    .OFF_W     (OFF_W)
  ) u_clip (
    .offset_i(addr_i[OFF_W-1:0]),
    .len_i   (LEN_W'(len_i)),
    .len_o   (clip_len)
  );

  spi_byte_engine #(
    .HALF_CLKS(SCLK_HALF)
  ) u_engine (
    .clk     (clk),
    .rst     (rst),
    .go_i    (issue),
    .tx_i    (tx_byte),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .rx_o    (eng_rx),
    .done_o  (eng_done),
    .active_o(eng_active)
  );

  // byte to shift out for the current transaction position
  always_comb begin
    tx_byte   = 8'h00;
    last_byte = 1'b0;
    need_data = 1'b0;
    case (txn_q)
      T_WREN: begin
        tx_byte   = OP_WR_ENABLE;
        last_byte = (idx_q == '0);
      end
      T_PROG: begin
        last_byte = (idx_q == IDX_W'(len_q) + IDX_W'(3));
        if (idx_q >= IDX_W'(4)) begin
          need_data = 1'b1;
          tx_byte   = data_i;
        end else begin
          case (idx_q[1:0])
            2'd0:    tx_byte = OP_PROGRAM;
            2'd1:    tx_byte = addr_q[23:16];
            2'd2:    tx_byte = addr_q[15:8];
            default: tx_byte = addr_q[7:0];
          endcase
        end
      end
      default: begin
        tx_byte   = (idx_q == '0) ? OP_READ_STAT : 8'h00;
        last_byte = (idx_q == IDX_W'(1));
      end
    endcase
  end

  assign issue   = (state_q == S_CMD) && !inflight_q && (!need_data || data_valid_i);
  assign tmo_hit = (tmo_q >= TMO_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      txn_q      <= T_WREN;
      nxt_q      <= T_WREN;
      idx_q      <= '0;
      inflight_q <= 1'b0;
      cs_n_q     <= 1'b1;
      gcnt_q     <= '0;
      tmo_q      <= '0;
      polling_q  <= 1'b0;
      addr_q     <= '0;
      len_q      <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
      busy_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (polling_q && !tmo_hit) tmo_q <= tmo_q + TMO_W'(1);
      if (issue) inflight_q <= 1'b1;
      case (state_q)
        S_IDLE: begin
          if (start_i) begin
            if (clip_len == '0) begin
              done_q <= 1'b1;
            end else begin
              addr_q  <= addr_i;
              len_q   <= clip_len;
              busy_q  <= 1'b1;
              nxt_q   <= T_WREN;
              gcnt_q  <= '0;
              state_q <= S_GAP;
            end
          end
        end
        S_GAP: begin
          if (gcnt_q == GAP_LAST) begin
            cs_n_q  <= 1'b0;
            txn_q   <= nxt_q;
            idx_q   <= '0;
            state_q <= S_CMD;
          end else begin
            gcnt_q <= gcnt_q + GAP_W'(1);
          end
        end
        default: begin
          if (eng_done) begin
            inflight_q <= 1'b0;
            if (!last_byte) begin
              idx_q <= idx_q + IDX_W'(1);
            end else begin
              cs_n_q <= 1'b1;
              gcnt_q <= '0;
              case (txn_q)
                T_WREN: begin
                  nxt_q   <= T_PROG;
                  state_q <= S_GAP;
                end
                T_PROG: begin
                  nxt_q     <= T_RDSR;
                  polling_q <= 1'b1;
                  tmo_q     <= '0;
                  state_q   <= S_GAP;
                end
                default: begin
                  if ((eng_rx & ST_BUSY_MASK) == 8'h00) begin
                    done_q    <= 1'b1;
                    busy_q    <= 1'b0;
                    polling_q <= 1'b0;
                    state_q   <= S_IDLE;
                  end else if (tmo_hit) begin
                    err_q     <= 1'b1;
                    busy_q    <= 1'b0;
                    polling_q <= 1'b0;
                    state_q   <= S_IDLE;
                  end else begin
                    state_q <= S_GAP;
                  end
                end
              endcase
            end
          end
        end
      endcase
    end
  end

  assign data_ready_o = (state_q == S_CMD) && !inflight_q && need_data;
  assign busy_o       = busy_q;
  assign done_o       = done_q;
  assign error_o      = err_q;
  assign cs_n_o       = cs_n_q;

  // cycles of chip-select high time, saturating at CS_GAP
  logic [GAP_W-1:0] hi_cnt_q;
  always_ff @(posedge clk) begin
    if (rst)                                        hi_cnt_q <= '0;
    else if (!cs_n_o)                               hi_cnt_q <= '0;
    else if (hi_cnt_q != GAP_W'(CS_GAP))            hi_cnt_q <= hi_cnt_q + GAP_W'(1);
  end

  p_sclk_low_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);
  p_cs_rise_on_byte_end_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |-> !eng_active);
  p_cs_high_gap_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> (hi_cnt_q >= GAP_W'(CS_GAP)));
  p_done_err_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(done_o && error_o));
  p_ready_in_window_r9: assert property (@(posedge clk) disable iff (rst)
    data_ready_o |-> !cs_n_o);
  p_start_sets_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o && (len_i != 9'd0)) |=> busy_o);
endmodule

// File: tb/spi_page_writer_tb.sv
module spi_page_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF  = 2;
  localparam int GAP   = 3;
  localparam int LIMIT = 400;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [8:0]  len_i = '0;
  logic [7:0]  data_i = '0;
  logic        data_valid_i = 1'b0;
  logic        data_ready_o, busy_o, done_o, error_o;
  logic        sclk_o, cs_n_o, mosi_o;
  logic        miso_i = 1'b0;

  spi_page_writer #(
    .SCLK_HALF (HALF),
    .CS_GAP    (GAP),
    .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .addr_i(addr_i), .len_i(len_i),
    .data_i(data_i), .data_valid_i(data_valid_i), .data_ready_o(data_ready_o),
    .busy_o(busy_o), .done_o(done_o), .error_o(error_o),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o), .miso_i(miso_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] cur [0:299];
  logic [7:0] prog_bytes [0:299];
  logic [7:0] log_op [0:63];
  int         log_n [0:63];
  logic [7:0] sh = '0;
  logic [7:0] st_sh = '0;
  int mbits = 0, mbytes = 0, n_txn = 0, bits_bad = 0, prog_n = 0;
  int busy_left = 0, cfg_polls = 0, mode_viol = 0;
  longint last_rise = 0, min_gap = 1000000;

  always @(negedge cs_n_o) if (!rst) begin
    mbits = 0; mbytes = 0;
    if (n_txn > 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
  end

  always @(posedge sclk_o) if (!rst && !cs_n_o) begin
    sh = {sh[6:0], mosi_o};
    mbits++;
    if (mbits % 8 == 0) begin
      if (mbytes < 300) cur[mbytes] = sh;
      mbytes++;
    end
  end

  always @(negedge sclk_o) if (!rst && !cs_n_o) begin
    if (mbits >= 8 && cur[0] == 8'h05) begin
      if (mbits == 8) st_sh = {6'b0, 1'b1, (busy_left > 0)};
      else            st_sh = {st_sh[6:0], 1'b0};
      miso_i = st_sh[7];
    end
  end

  always @(posedge cs_n_o) if (!rst) begin
    if (n_txn < 64) begin
      log_op[n_txn] = (mbytes > 0) ? cur[0] : 8'h00;
      log_n[n_txn]  = mbytes;
    end
    n_txn++;
    if (mbits % 8 != 0) bits_bad++;
    if (mbytes > 0 && cur[0] == 8'h02) begin
      prog_n = mbytes;
      for (int i = 0; i < 300; i++) prog_bytes[i] = cur[i];
      busy_left = cfg_polls;
    end else if (mbytes > 0 && cur[0] == 8'h05 && busy_left > 0) begin
      busy_left--;
    end
    last_rise = cyc;
  end

  // SPI mode 0 monitor (R5)
  logic prev_sclk = 1'b0, prev_mosi = 1'b0;
  always @(negedge clk) if (!rst) begin
    if (cs_n_o && sclk_o) mode_viol++;
    if (!cs_n_o && sclk_o && prev_sclk && (mosi_o != prev_mosi)) mode_viol++;
    prev_sclk = sclk_o;
    prev_mosi = mosi_o;
  end

  // ---------------- payload source ----------------
  logic [7:0] src [0:299];
  int src_n = 0, src_idx = 0;
  bit src_stall = 0;
  always @(posedge clk) if (data_valid_i && data_ready_o) src_idx <= src_idx + 1;
  always @(negedge clk) begin
    data_valid_i <= (src_idx < src_n) && !(src_stall && (cyc % 5 < 2));
    data_i       <= src[(src_idx < 300) ? src_idx : 0];
  end

  int done_cnt = 0, err_cnt = 0;
  always @(posedge clk) if (!rst) begin
    if (done_o)  done_cnt++;
    if (error_o) err_cnt++;
  end

  // ---------------- scenarios ----------------
  task automatic test_reset();
    chk("R11", "busy after reset", busy_o, 0);
    chk("R5", "cs_n after reset", cs_n_o, 1);
    chk("R5", "sclk after reset", sclk_o, 0);
    chk("R9", "ready after reset", data_ready_o, 0);
    chk("R1", "done after reset", done_o, 0);
  endtask

  task automatic test_zero_len();
    int d0 = done_cnt;
    n_txn = 0; src_idx = 0; src_n = 4;
    @(negedge clk); addr_i = 24'h000040; len_i = 9'd0; start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R1", "done one cycle after zero-length start", done_o, 1);
    chk("R1", "busy on zero length", busy_o, 0);
    repeat (60) @(negedge clk);
    chk("R1", "transactions on zero length", n_txn, 0);
    chk("R1", "stream bytes taken on zero length", src_idx, 0);
    chk("R1", "done pulses", done_cnt - d0, 1);
    src_n = 0;
  endtask

  task automatic run_write(input logic [23:0] addr, input int len, input int polls,
                           input bit stall, input bit poke, input bit exp_err,
                           input int exp_reads);
    int eff, room, d0, e0, guard, mism;
    room = 256 - addr[7:0];
    eff  = (len > room) ? room : len;
    n_txn = 0; bits_bad = 0; mode_viol = 0; min_gap = 1000000; prog_n = 0;
    cfg_polls = polls; src_stall = stall; src_idx = 0;
    src_n = (len > 300) ? 300 : len;
    for (int i = 0; i < 300; i++) src[i] = 8'(addr[7:0] ^ (i * 37 + len));
    d0 = done_cnt; e0 = err_cnt;
    @(negedge clk); addr_i = addr; len_i = 9'(len); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk("R11", "busy after start", busy_o, 1);
    guard = 0;
    while (done_cnt == d0 && err_cnt == e0 && guard < 60000) begin
      @(negedge clk);
      guard++;
      if (poke && guard == 200) begin
        addr_i = 24'h000000; len_i = 9'd5; start_i = 1'b1;
      end else begin
        start_i = 1'b0;
      end
    end
    chk("R6", "request finished", (guard < 60000), 1);
    repeat (10) @(negedge clk);
    chk("R11", "busy after finish", busy_o, 0);
    chk("R2", "write-enable opcode", log_op[0], 8'h06);
    chk("R2", "write-enable length", log_n[0], 1);
    chk("R3", "program opcode", log_op[1], 8'h02);
    chk("R4", "program transaction bytes", log_n[1], 4 + eff);
    chk("R3", "address byte 23:16", prog_bytes[1], addr[23:16]);
    chk("R3", "address byte 15:8", prog_bytes[2], addr[15:8]);
    chk("R3", "address byte 7:0", prog_bytes[3], addr[7:0]);
    mism = 0;
    for (int i = 0; i < eff; i++) if (prog_bytes[4 + i] !== src[i]) mism++;
    chk("R3", "payload mismatches", mism, 0);
    chk("R9", "stream bytes consumed", src_idx, eff);
    for (int k = 2; k < n_txn && k < 64; k++) begin
      chk("R6", "status opcode", log_op[k], 8'h05);
      chk("R6", "status transaction bytes", log_n[k], 2);
    end
    chk("R6", "status reads", n_txn - 2, exp_reads);
    chk("R5", "windows not ending on a byte boundary", bits_bad, 0);
    chk("R5", "mode 0 violations", mode_viol, 0);
    chk("R7", "minimum cs high gap ok", (min_gap >= GAP), 1);
    chk(exp_err ? "R8" : "R6", "done pulses", done_cnt - d0, exp_err ? 0 : 1);
    chk("R8", "error pulses", err_cnt - e0, exp_err ? 1 : 0);
    src_stall = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: got hung run expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_zero_len();
    // R4: count above a full page at page start is clipped to 256
    run_write(24'h5A1200, 300, 2, 0, 0, 0, 3);
    // R4 R9 R10: mid-page clip to 16, stalled stream, start ignored while busy
    run_write(24'hABCDF0, 40, 0, 1, 1, 0, 1);
    // R4: last byte of a page leaves room for one byte
    run_write(24'h0000FF, 9, 1, 0, 0, 0, 2);
    // R8: final clear read lands after the limit, done wins
    run_write(24'h010203, 3, 5, 0, 0, 0, 6);
    // R8: still busy after the limit, error
    run_write(24'h010203, 3, 6, 0, 0, 1, 6);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule